// File: doc/BRIEF.md
# Interprocessor Mailbox Controller

This block is a memory-mapped mailbox through which a local processor hands short fixed-length messages to a remote processor and receives an acknowledge in return. It holds a bank of identical channels. Each channel has a 64-byte register window at `channel × 0x40`, an eight-word message buffer, a source and a destination interrupt mask, and an ownership state machine. Each channel moves through idle, owned-ready, sending and acknowledged, and then back.

A sender first writes the global unlock key. It then claims a channel by writing its one-hot interrupt bit to the source register and reading it back. Next it selects and unmasks a destination line, fills the buffer and rings the doorbell by writing its own bit to the send register. The acknowledge comes either automatically one cycle later or from the receiving side. The sender clears the acknowledge to send again, or releases the channel back to idle. All interrupt lines of all channels are merged onto two 32-bit output vectors.

Top module: `ipc_mbox_ctrl`

## Requirements
- R1: After reset every channel is idle (mode register reads 0x10), the lock register reads 1, the mask register reads all ones, and both interrupt vectors are zero.
- R2: Writing 0x1ACCE551 to address 0xA00 makes the lock register read 0. Any other value written there makes it read 1.
- R3: While the lock register reads 1, writes to any channel register are ignored. Reads keep working.
- R4: Writing a one-hot value to the source register (offset 0x00) of an idle channel claims it: the source register reads back that value and the mode register shows ready (bit 5) with idle (bit 4) clear. Non-one-hot values, and source writes to a non-idle channel, are ignored.
- R5: Each channel has eight message words at offset 0x20 + 4·i, independent of other channels. Any register's value appears on the read data one cycle after its address is presented.
- R6: In the ready state, writing the source value to the send register (offset 0x1C) latches the destination register (offset 0x04) into the destination status register (offset 0x0C). It also drives the unmasked status bits onto `irq_dst` from the next cycle. A send write with any other value is ignored.
- R7: A status bit whose interrupt mask bit (offset 0x14) is 1 does not appear on `irq_dst`.
- R8: With mode bit 0 set (written at offset 0x10), the channel enters the acknowledged state (mode bit 7) one cycle after the send takes effect, and its source value appears on `irq_src`.
- R9: With mode bit 0 clear, a sent channel reads mode bits 7, 5 and 4 all zero until the destination value is written to the acknowledge-clear register (offset 0x18). That write moves it to acknowledged.
- R10: In the acknowledged state, writing the source value to offset 0x18 returns the channel to ready, clears its destination status and removes it from `irq_src`.
- R11: Writing the source value to the release register (offset 0x08) of a non-idle channel returns it to idle and clears its source, destination and status registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented one cycle earlier |
| irq_dst | output | 32 | Merged unmasked destination interrupt lines of all channels |
| irq_src | output | 32 | Merged acknowledge interrupt lines of all channels |

## Verification
A channel whose ownership state goes wrong shows on the mode register read and on `irq_src` at the very next cycle. A stale or wrongly latched destination status or mask shows on `irq_dst` one cycle after the write that should have changed it. Because the bench's model predicts both interrupt vectors and the read data every cycle, a divergence in a channel's state is reported on the cycle it first becomes visible. It does not have to wait for a later directed read. A broken lock shows as a configuration write that takes effect when it should not.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READY = 2'd1,
    CH_SENT  = 2'd2,
    CH_ACKED = 2'd3
  } ch_state_e;

  // Word index inside a channel window; message words occupy indices 8..15
  localparam logic [3:0] WI_SRC    = 4'h0;
  localparam logic [3:0] WI_DST    = 4'h1;
  localparam logic [3:0] WI_REL    = 4'h2;
  localparam logic [3:0] WI_DSTAT  = 4'h3;
  localparam logic [3:0] WI_MODE   = 4'h4;
  localparam logic [3:0] WI_MASK   = 4'h5;
  localparam logic [3:0] WI_ACKCLR = 4'h6;
  localparam logic [3:0] WI_SEND   = 4'h7;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

  function automatic logic is_onehot(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/mbox_lock.sv
module mbox_lock #(
  parameter int              DW        = 32,
  parameter int              AW        = 12,
  parameter logic [AW-1:0]   LOCK_ADDR = 12'hA00,
  parameter logic [DW-1:0]   KEY       = 32'h1ACC_E551
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          locked_o
);

  always_ff @(posedge clk) begin
    if (rst)
      locked_o <= 1'b1;
    else if (we && addr == LOCK_ADDR)
      locked_o <= (wdata != KEY);
  end

endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int DW   = 32,
  parameter int MSGW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    rd_idx,
  output logic [DW-1:0] rd_word_q,
  output logic [DW-1:0] irq_dst_o,
  output logic [DW-1:0] irq_src_o,
  output logic          is_idle,
  output logic          is_sent,
  output logic          is_acked,
  output logic          auto_o
);

  localparam int MI_W = (MSGW > 1) ? $clog2(MSGW) : 1;

  ch_state_e     st_q;
  logic [DW-1:0] src_q, dst_q, dstat_q, mask_q;
  logic          auto_q;
  logic [DW-1:0] msg_mem [MSGW];
  logic [DW-1:0] ctrl_word;
  logic          release_hit;

  assign release_hit = wr_en && wr_idx == WI_REL && wdata == src_q && st_q != CH_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CH_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      dstat_q <= '0;
      mask_q  <= '1;
      auto_q  <= 1'b0;
    end else begin
      if (wr_en && wr_idx == WI_DST)  dst_q  <= wdata;
      if (wr_en && wr_idx == WI_MASK) mask_q <= wdata;
      if (wr_en && wr_idx == WI_MODE) auto_q <= wdata[0];
      if (release_hit) begin
        st_q    <= CH_IDLE;
        src_q   <= '0;
        dst_q   <= '0;
        dstat_q <= '0;
      end else begin
        unique case (st_q)
          CH_IDLE:
            if (wr_en && wr_idx == WI_SRC && is_onehot(32'(wdata))) begin
              st_q  <= CH_READY;
              src_q <= wdata;
            end
          CH_READY:
            if (wr_en && wr_idx == WI_SEND && wdata == src_q) begin
              st_q    <= CH_SENT;
              dstat_q <= dst_q;
            end
          CH_SENT:
            if (auto_q)
              st_q <= CH_ACKED;
            else if (wr_en && wr_idx == WI_ACKCLR && wdata == dst_q && dst_q != '0)
              st_q <= CH_ACKED;
          CH_ACKED:
            if (wr_en && wr_idx == WI_ACKCLR && wdata == src_q) begin
              st_q    <= CH_READY;
              dstat_q <= '0;
            end
          default: st_q <= CH_IDLE;
        endcase
      end
    end
  end

  // Message buffer: plain write port and registered read, suitable for RAM inference
  always_ff @(posedge clk) begin
    if (wr_en && wr_idx[3])
      msg_mem[wr_idx[MI_W-1:0]] <= wdata;
  end

  always_comb begin
    ctrl_word = '0;
    case (rd_idx[2:0])
      3'd0: ctrl_word = src_q;
      3'd1: ctrl_word = dst_q;
      3'd3: ctrl_word = dstat_q;
      3'd4: ctrl_word = DW'({(st_q == CH_ACKED), 1'b0, (st_q == CH_READY),
                             (st_q == CH_IDLE), 3'b000, auto_q});
      3'd5: ctrl_word = mask_q;
      default: ctrl_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rd_idx[3])
      rd_word_q <= msg_mem[rd_idx[MI_W-1:0]];
    else
      rd_word_q <= ctrl_word;
  end

  assign irq_dst_o = dstat_q & ~mask_q;
  assign irq_src_o = (st_q == CH_ACKED) ? src_q : '0;
  assign is_idle   = (st_q == CH_IDLE);
  assign is_sent   = (st_q == CH_SENT);
  assign is_acked  = (st_q == CH_ACKED);
  assign auto_o    = auto_q;

endmodule

// File: rtl/ipc_mbox_ctrl.sv
module ipc_mbox_ctrl #(
  parameter int            NCH       = 4,
  parameter int            DW        = 32,
  parameter int            AW        = 12,
  parameter int            MSGW      = 8,
  parameter logic [AW-1:0] LOCK_ADDR = 12'hA00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [DW-1:0] irq_dst,
  output logic [DW-1:0] irq_src
);

  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WIN_END = NCH * 64;

  logic                  locked;
  logic                  in_win;
  logic [DW-1:0]         ch_rd  [NCH];
  logic [DW-1:0]         ch_dst [NCH];
  logic [DW-1:0]         ch_src [NCH];
  logic [NCH-1:0]        st_idle, st_sent, st_acked, auto_on;
  logic [CH_W-1:0]       sel_ch_q;
  logic [1:0]            rd_kind_q;   // 0 none, 1 channel, 2 lock
  logic                  lock_rd_q;

  assign in_win = (32'(bus_addr) < WIN_END);

  mbox_lock #(
    .DW(DW), .AW(AW), .LOCK_ADDR(LOCK_ADDR), .KEY(DW'(mbox_pkg::UNLOCK_KEY))
  ) u_lock (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .locked_o(locked)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic hit;
    assign hit = in_win && (bus_addr[AW-1:6] == (AW-6)'(k));
    mbox_chan #(.DW(DW), .MSGW(MSGW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(bus_we && !locked && hit),
      .wr_idx(bus_addr[5:2]),
      .wdata(bus_wdata),
      .rd_idx(bus_addr[5:2]),
      .rd_word_q(ch_rd[k]),
      .irq_dst_o(ch_dst[k]),
      .irq_src_o(ch_src[k]),
      .is_idle(st_idle[k]),
      .is_sent(st_sent[k]),
      .is_acked(st_acked[k]),
      .auto_o(auto_on[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_kind_q <= 2'd0;
      sel_ch_q  <= '0;
      lock_rd_q <= 1'b1;
    end else begin
      sel_ch_q  <= bus_addr[6 +: CH_W];
      lock_rd_q <= locked;
      if (bus_addr == LOCK_ADDR) rd_kind_q <= 2'd2;
      else if (in_win)           rd_kind_q <= 2'd1;
      else                       rd_kind_q <= 2'd0;
    end
  end

  always_comb begin
    case (rd_kind_q)
      2'd1:    bus_rdata = ch_rd[sel_ch_q];
      2'd2:    bus_rdata = DW'(lock_rd_q);
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    irq_dst = '0;
    irq_src = '0;
    for (int k = 0; k < NCH; k++) begin
      irq_dst = irq_dst | ch_dst[k];
      irq_src = irq_src | ch_src[k];
    end
  end

endmodule

// File: rtl/ipc_mbox_chk.sv
module ipc_mbox_chk #(
  parameter int            NCH       = 4,
  parameter int            DW        = 32,
  parameter int            AW        = 12,
  parameter logic [AW-1:0] LOCK_ADDR = 12'hA00
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_we,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  irq_dst,
  input logic [DW-1:0]  irq_src,
  input logic           locked,
  input logic [NCH-1:0] st_idle,
  input logic [NCH-1:0] st_sent,
  input logic [NCH-1:0] st_acked,
  input logic [NCH-1:0] auto_on
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_dst == '0 && irq_src == '0));

  // R2
  unlock_key_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == LOCK_ADDR && bus_wdata == DW'(32'h1ACC_E551)) |=> !locked);

  // R3
  locked_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && bus_we && 32'(bus_addr) < NCH * 64) |=> $stable(st_idle));

  // R6
  dst_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_dst != '0) |-> (st_idle != {NCH{1'b1}}));

  // R8
  auto_ack_next_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && (st_sent & auto_on) != '0)
      |=> ((st_acked & $past(st_sent & auto_on)) == $past(st_sent & auto_on)));

endmodule

bind ipc_mbox_ctrl ipc_mbox_chk #(
  .NCH(NCH), .DW(DW), .AW(AW), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_dst(irq_dst), .irq_src(irq_src),
  .locked(locked), .st_idle(st_idle), .st_sent(st_sent),
  .st_acked(st_acked), .auto_on(auto_on)
);

// File: tb/ipc_mbox_ctrl_test.sv
`timescale 1ns/1ps
module ipc_mbox_ctrl_test;

  localparam int NCH = 4;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_dst, irq_src;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ipc_mbox_ctrl #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_dst(irq_dst), .irq_src(irq_src)
  );

  // ---------------- behavioural reference model ----------------
  int          m_st    [NCH];   // 0 idle, 1 ready, 2 sent, 3 acked
  logic [31:0] m_src   [NCH];
  logic [31:0] m_dst   [NCH];
  logic [31:0] m_dstat [NCH];
  logic [31:0] m_mask  [NCH];
  bit          m_auto  [NCH];
  logic [31:0] m_mem   [NCH][8];
  bit          m_lock;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int c, w;
    if (a == 12'hA00) return {31'd0, m_lock};
    if (int'(a) >= NCH * 64) return 32'd0;
    c = int'(a) / 64;
    w = (int'(a) % 64) / 4;
    if (w >= 8) return m_mem[c][w - 8];
    case (w)
      0: return m_src[c];
      1: return m_dst[c];
      3: return m_dstat[c];
      4: return {24'd0, m_st[c] == 3, 1'b0, m_st[c] == 1, m_st[c] == 0, 3'd0, m_auto[c]};
      5: return m_mask[c];
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit onehot(input logic [31:0] v);
    return v != 0 && $countones(v) == 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin
        m_st[k] = 0; m_src[k] = 0; m_dst[k] = 0; m_dstat[k] = 0;
        m_mask[k] = '1; m_auto[k] = 0;
      end
      m_lock = 1;
      m_rd = 0;
    end else begin
      int c, w;
      bit wv;
      m_rd = model_read(bus_addr);
      c  = int'(bus_addr) / 64;
      w  = (int'(bus_addr) % 64) / 4;
      wv = bus_we && !m_lock && int'(bus_addr) < NCH * 64;
      for (int k = 0; k < NCH; k++) begin
        bit h;
        bit old_auto;
        h = wv && c == k;
        old_auto = m_auto[k];
        if (h && w == 2 && bus_wdata == m_src[k] && m_st[k] != 0) begin
          m_st[k] = 0; m_src[k] = 0; m_dst[k] = 0; m_dstat[k] = 0;
        end else if (m_st[k] == 0) begin
          if (h && w == 0 && onehot(bus_wdata)) begin m_st[k] = 1; m_src[k] = bus_wdata; end
        end else if (m_st[k] == 1) begin
          if (h && w == 7 && bus_wdata == m_src[k]) begin m_st[k] = 2; m_dstat[k] = m_dst[k]; end
        end else if (m_st[k] == 2) begin
          if (old_auto) m_st[k] = 3;
          else if (h && w == 6 && bus_wdata == m_dst[k] && m_dst[k] != 0) m_st[k] = 3;
        end else begin
          if (h && w == 6 && bus_wdata == m_src[k]) begin m_st[k] = 1; m_dstat[k] = 0; end
        end
        if (h && w == 1) m_dst[k] = bus_wdata;
        if (h && w == 5) m_mask[k] = bus_wdata;
        if (h && w == 4) m_auto[k] = bus_wdata[0];
        if (h && w >= 8) m_mem[k][w - 8] = bus_wdata;
      end
      if (bus_we && bus_addr == 12'hA00) m_lock = (bus_wdata != KEY);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [31:0] ed, es;
      ed = 0; es = 0;
      for (int k = 0; k < NCH; k++) begin
        ed |= m_dstat[k] & ~m_mask[k];
        if (m_st[k] == 3) es |= m_src[k];
      end
      chk("R5 cycle read data", bus_rdata, m_rd);
      chk("R6 cycle irq_dst", irq_dst, ed);
      chk("R8 cycle irq_src", irq_src, es);
    end
  end

  // ---------------- bus tasks ----------------
  function automatic logic [11:0] ra(input int c, input int w);
    return 12'(c * 64 + w * 4);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(ra(0, 4), v); chk("R1 ch0 mode idle", v, 32'h10);
    rd(ra(3, 4), v); chk("R1 ch3 mode idle", v, 32'h10);
    rd(ra(2, 5), v); chk("R1 mask all ones", v, 32'hFFFF_FFFF);
    rd(12'hA00, v);  chk("R1 lock reads 1", v, 32'h1);
    chk("R1 irq_dst zero", irq_dst, 0);
    chk("R1 irq_src zero", irq_src, 0);

    // R3 writes ignored while locked
    wr(ra(0, 0), 32'h4);
    rd(ra(0, 0), v); chk("R3 src unchanged while locked", v, 0);
    rd(ra(0, 4), v); chk("R3 mode still idle while locked", v, 32'h10);

    // R2 lock key
    wr(12'hA00, 32'h1234_5678);
    rd(12'hA00, v); chk("R2 wrong key stays locked", v, 32'h1);
    wr(12'hA00, KEY);
    rd(12'hA00, v); chk("R2 key unlocks", v, 32'h0);

    // R4 claim
    wr(ra(0, 0), 32'h4);
    rd(ra(0, 0), v); chk("R4 src read-back", v, 32'h4);
    rd(ra(0, 4), v); chk("R4 mode ready", v, 32'h20);
    wr(ra(0, 0), 32'h8);
    rd(ra(0, 0), v); chk("R4 second claim ignored", v, 32'h4);
    wr(ra(1, 0), 32'h6);
    rd(ra(1, 4), v); chk("R4 non-one-hot claim ignored", v, 32'h10);

    // R5 message buffers per channel
    for (int i = 0; i < 8; i++) wr(ra(0, 8 + i), 32'hA000_0000 + i);
    for (int i = 0; i < 8; i++) wr(ra(1, 8 + i), 32'hB000_0100 + i);
    rd(ra(0, 15), v); chk("R5 ch0 word 7", v, 32'hA000_0007);
    rd(ra(1, 8), v);  chk("R5 ch1 word 0", v, 32'hB000_0100);
    rd(ra(0, 8), v);  chk("R5 ch0 word 0 kept", v, 32'hA000_0000);

    // R6/R8 send in automatic mode
    wr(ra(0, 1), 32'h200);
    wr(ra(0, 5), ~32'h200);
    wr(ra(0, 4), 32'h1);
    wr(ra(0, 7), 32'h8);
    rd(ra(0, 4), v); chk("R6 wrong send ignored", v, 32'h21);
    wr(ra(0, 7), 32'h4);
    chk("R6 irq_dst after send", irq_dst, 32'h200);
    chk("R8 irq_src not yet", irq_src, 0);
    @(negedge clk);
    chk("R8 irq_src one cycle later", irq_src, 32'h4);
    rd(ra(0, 4), v); chk("R8 mode acked", v, 32'h81);
    rd(ra(0, 3), v); chk("R6 dstat latched", v, 32'h200);

    // R7/R9 masked manual-mode channel
    wr(ra(1, 0), 32'h1);
    wr(ra(1, 1), 32'h8);
    wr(ra(1, 7), 32'h1);
    chk("R7 masked bit absent", irq_dst, 32'h200);
    rd(ra(1, 3), v); chk("R7 dstat still set", v, 32'h8);
    repeat (3) @(negedge clk);
    rd(ra(1, 4), v); chk("R9 manual stays sent", v, 32'h00);
    wr(ra(1, 6), 32'h1);
    rd(ra(1, 4), v); chk("R9 src bit does not ack sent", v, 32'h00);
    wr(ra(1, 6), 32'h8);
    rd(ra(1, 4), v); chk("R9 manual ack", v, 32'h80);
    chk("R9 irq_src both", irq_src, 32'h5);

    // R10 clear acknowledge
    wr(ra(0, 6), 32'h4);
    rd(ra(0, 4), v); chk("R10 back to ready", v, 32'h21);
    rd(ra(0, 3), v); chk("R10 dstat cleared", v, 32'h0);
    chk("R10 irq_dst cleared", irq_dst, 32'h0);
    chk("R10 irq_src ch1 only", irq_src, 32'h1);

    // R11 release
    wr(ra(0, 2), 32'h4);
    rd(ra(0, 4), v); chk("R11 released idle", v, 32'h11);
    rd(ra(0, 0), v); chk("R11 src cleared", v, 32'h0);
    rd(ra(0, 1), v); chk("R11 dst cleared", v, 32'h0);
    wr(ra(0, 0), 32'h10);
    rd(ra(0, 0), v); chk("R4 reclaim after release", v, 32'h10);

    // R3 relock, release attempt ignored
    wr(12'hA00, 32'h0);
    rd(12'hA00, v); chk("R2 relock", v, 32'h1);
    wr(ra(1, 2), 32'h1);
    rd(ra(1, 4), v); chk("R3 release ignored while locked", v, 32'h80);
    chk("R3 irq_src kept", irq_src, 32'h1);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule